// File: doc/BRIEF.md
# Charging Port Over-Current Retry Manager

This block drives the power-enable outputs of the downstream ports of a small hub (two by default) from active-low over-current sense inputs. A per-port charging-enable field and a host-link input pick, once per reset, one of three port modes:

- **Dedicated charging.** The block recovers from faults by itself. A faulted port is switched off, re-enabled after a short off period, and probed for a lingering fault. After a fixed number of short attempts it moves to a long off period, which repeats for as long as the fault stays. A port is never disabled for good.
- **Charging downstream** and **standard.** Port power follows the host power request, gated by the current recognised fault. Nothing is latched.

All timing counts a one-millisecond tick supplied from outside. A gang-mode input chooses between two policies: any port's fault removes power from every port, or only the faulted port loses power.

Control is a small configuration state machine plus one port state machine per port. The configuration machine has two states. `CFG_WAIT` counts `INIT_MS` ticks after reset. The transition `WAIT→RUN` raises `cfg_done` and loads every port's mode.

Each port machine has six states:
- `PS_INIT` waits for configuration.
- `PS_HOST` holds a host-controlled port. It is terminal.
- `PS_ON` is a powered dedicated-charging port.
- `PS_PROBE` is the first `PRESENT_MS` ticks after a re-enable.
- `PS_OFF_SHORT` is a short off period.
- `PS_OFF_LONG` is a long off period.

Its transitions are:
- init→host or init→on, on configuration;
- on→off, on a recognised fault;
- probe→off, on any fault sample;
- probe→on, when the window ends clean;
- off→probe, when the off timer expires.

Top module: `chgport_retry_mgr`

## Requirements
- R1: Bit k of `chg_en` (k = 1..NUM_PORTS) configures port k, which is vector index k-1 of all per-port ports. A port whose bit is 0 is standard mode. A port whose bit is 1 is dedicated charging if `host_link` is 0 at configuration time, and charging downstream if `host_link` is 1.
- R2: From reset until `INIT_MS` ticks have elapsed, `cfg_done` and all power enables are 0. In the cycle after configuration, dedicated-charging ports drive their enable high.
- R3: Over-current is `ocs_n` low. It passes a two-flop synchroniser and is recognised only after it has been seen on `DEB_MS` consecutive ticks, so shorter pulses have no effect. A powered dedicated-charging port drops its enable one cycle after recognition.
- R4: With `gang_mode`=1, a fault recognised on any port acts on every port. With `gang_mode`=0, it acts only on its own port.
- R5: A faulted dedicated-charging port stays off for `SHORT_OFF_MS` ticks and is then re-enabled. If any synchronised fault sample occurs within `PRESENT_MS` ticks of re-enable, the port goes off again.
- R6: The first `SHORT_TRIES` (3) off periods of a fault episode use `SHORT_OFF_MS` (1000).
- R7: Each later off period lasts `LONG_OFF_MS` (10000) ticks, without limit. The port always re-enables when the period ends.
- R8: The attempt count clears after `CLEAN_MS` fault-free ticks in `PS_ON`. A fault recognised before that continues the count.
- R9: A host-controlled port's enable equals `host_req` AND NOT its current recognised fault. Nothing is latched, so power returns when the fault clears.
- R10: Port modes are fixed at configuration. Later changes of `chg_en` or `host_link` have no effect until the next reset.
- R11: `port_status[2k+1:2k]` gives the state of port index k:
  - 00: powered dedicated-charging;
  - 01: off in short retry;
  - 10: off in long retry;
  - 11: host-controlled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_1ms | input | 1 | One-cycle pulse per millisecond |
| ocs_n | input | NUM_PORTS | Active-low over-current sense per port |
| chg_en | input | NUM_PORTS (bits NUM_PORTS:1) | Charging enable, bit k for port k |
| host_link | input | 1 | Hub attached to a host (sampled at configuration) |
| gang_mode | input | 1 | 1 = ganged power switching, 0 = individual |
| host_req | input | NUM_PORTS | Host power request per port |
| port_pwr_en | output | NUM_PORTS | Port power enables |
| port_status | output | 2*NUM_PORTS | Per-port state code, 2 bits each |
| cfg_done | output | 1 | Configuration complete |

## Verification
A port machine stuck in or skipping a state shows at `port_status` within one cycle of the wrong transition. It shows at `port_pwr_en` within one cycle for off/on errors, or within one off period for a wrong short/long choice.

A wrong attempt count only becomes visible at the next fault. The bench therefore faults a port both just before and just after the clean interval and checks which off-period code follows.

A broken debounce shows up as power loss from a glitch shorter than `DEB_MS` ticks. A broken gang selection shows up as the wrong subset of enables dropping.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

    typedef enum logic [2:0] {
        PS_INIT,
        PS_HOST,
        PS_ON,
        PS_PROBE,
        PS_OFF_SHORT,
        PS_OFF_LONG
    } port_state_t;

    typedef enum logic [1:0] {
        STAT_POWERED = 2'b00,
        STAT_SHORT   = 2'b01,
        STAT_LONG    = 2'b10,
        STAT_HOST    = 2'b11
    } port_stat_t;

    typedef enum logic {
        CFG_WAIT,
        CFG_RUN
    } cfg_state_t;

endpackage

// File: rtl/cpm_cfg_ctl.sv
module cpm_cfg_ctl
    import cpm_pkg::*;
#(
    parameter int INIT_MS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic cfg_load,
    output logic cfg_done
);

    localparam int CW = $clog2(INIT_MS + 1);

    cfg_state_t       state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic             last_tick;

    assign last_tick = tick && (cnt_q == CW'(INIT_MS - 1));

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_WAIT: if (last_tick) state_d = CFG_RUN;
            CFG_RUN:  state_d = CFG_RUN;
            default:  state_d = CFG_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CFG_WAIT && tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        cfg_load = (state_q == CFG_WAIT) && (state_d == CFG_RUN);
        cfg_done = (state_q == CFG_RUN);
    end

    // R2: configuration, once done, stays done until reset
    p_cfg_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

    // R2: the load pulse happens exactly once, right before done rises
    p_load_then_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (cfg_done && !cfg_load));

endmodule

// File: rtl/cpm_sync_deb.sv
module cpm_sync_deb #(
    parameter int DEB_MS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ocs_n,
    output logic flt_raw,
    output logic flt_deb
);

    localparam int CW = $clog2(DEB_MS + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], ~ocs_n};
            if (!sync_q[1])
                cnt_q <= '0;
            else if (tick && cnt_q != CW'(DEB_MS))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign flt_raw = sync_q[1];
    assign flt_deb = (cnt_q == CW'(DEB_MS));

    // R3: a clean synchronised sample removes the recognised fault next cycle
    p_deb_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_raw |=> !flt_deb);

endmodule

// File: rtl/cpm_port_fsm.sv
module cpm_port_fsm
    import cpm_pkg::*;
#(
    parameter int SHORT_OFF_MS = 1000,
    parameter int LONG_OFF_MS  = 10000,
    parameter int PRESENT_MS   = 10,
    parameter int CLEAN_MS     = 1000,
    parameter int SHORT_TRIES  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cfg_load,
    input  logic       cfg_dcp,
    input  logic       flt_deb,
    input  logic       flt_raw,
    input  logic       host_req,
    output logic       pwr_en,
    output logic [1:0] status
);

    localparam int MAX_A = (LONG_OFF_MS > SHORT_OFF_MS) ? LONG_OFF_MS : SHORT_OFF_MS;
    localparam int MAX_B = (CLEAN_MS > PRESENT_MS) ? CLEAN_MS : PRESENT_MS;
    localparam int TMAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int AW    = $clog2(SHORT_TRIES + 1);

    port_state_t   state_q, state_d;
    logic [TW-1:0] tmr_q;
    logic [AW-1:0] att_q;
    port_state_t   off_pick;

    assign off_pick = (att_q < AW'(SHORT_TRIES)) ? PS_OFF_SHORT : PS_OFF_LONG;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_INIT:      if (cfg_load) state_d = cfg_dcp ? PS_ON : PS_HOST;
            PS_HOST:      state_d = PS_HOST;
            PS_ON:        if (flt_deb) state_d = off_pick;
            PS_PROBE: begin
                if (flt_raw)
                    state_d = off_pick;
                else if (tick && tmr_q == TW'(PRESENT_MS - 1))
                    state_d = PS_ON;
            end
            PS_OFF_SHORT: if (tick && tmr_q == TW'(SHORT_OFF_MS - 1)) state_d = PS_PROBE;
            PS_OFF_LONG:  if (tick && tmr_q == TW'(LONG_OFF_MS - 1))  state_d = PS_PROBE;
            default:      state_d = PS_INIT;
        endcase
    end

    // state register, timer and attempt count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_INIT;
            tmr_q   <= '0;
            att_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                tmr_q <= '0;
            else if (tick && tmr_q != TW'(TMAX))
                tmr_q <= tmr_q + 1'b1;
            if (state_q != PS_OFF_SHORT && state_d == PS_OFF_SHORT)
                att_q <= att_q + 1'b1;
            else if (state_q == PS_ON && state_d == PS_ON && tmr_q >= TW'(CLEAN_MS))
                att_q <= '0;
        end
    end

    // outputs
    always_comb begin
        pwr_en = 1'b0;
        status = STAT_POWERED;
        unique case (state_q)
            PS_INIT:      begin pwr_en = 1'b0;                 status = STAT_POWERED; end
            PS_HOST:      begin pwr_en = host_req && !flt_deb; status = STAT_HOST;    end
            PS_ON:        begin pwr_en = 1'b1;                 status = STAT_POWERED; end
            PS_PROBE:     begin pwr_en = 1'b1;                 status = STAT_POWERED; end
            PS_OFF_SHORT: begin pwr_en = 1'b0;                 status = STAT_SHORT;   end
            PS_OFF_LONG:  begin pwr_en = 1'b0;                 status = STAT_LONG;    end
            default:      begin pwr_en = 1'b0;                 status = STAT_POWERED; end
        endcase
    end

    // R10: host-controlled mode is terminal
    p_mode_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_HOST) |=> (state_q == PS_HOST));

    // R3: a recognised fault on a powered port removes power next cycle
    p_fault_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_ON && flt_deb) |=> !pwr_en);

    // R6: attempt count never exceeds the short-try limit
    p_short_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        att_q <= AW'(SHORT_TRIES));

    // R7: a long off period starts only after all short attempts are used
    p_long_after_tries_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_OFF_LONG && state_d == PS_OFF_LONG) |-> (att_q == AW'(SHORT_TRIES)));

    // R5: an off period always ends in a probe, never directly in power-on
    p_off_to_probe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OFF_SHORT && state_d != PS_OFF_SHORT) |-> (state_d == PS_PROBE));

endmodule

// File: rtl/chgport_retry_mgr.sv
module chgport_retry_mgr
    import cpm_pkg::*;
#(
    parameter int NUM_PORTS    = 2,
    parameter int INIT_MS      = 4,
    parameter int DEB_MS       = 8,
    parameter int PRESENT_MS   = 10,
    parameter int SHORT_OFF_MS = 1000,
    parameter int LONG_OFF_MS  = 10000,
    parameter int CLEAN_MS     = 1000,
    parameter int SHORT_TRIES  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_1ms,
    input  logic [NUM_PORTS-1:0]   ocs_n,
    input  logic [NUM_PORTS:1]     chg_en,
    input  logic                   host_link,
    input  logic                   gang_mode,
    input  logic [NUM_PORTS-1:0]   host_req,
    output logic [NUM_PORTS-1:0]   port_pwr_en,
    output logic [2*NUM_PORTS-1:0] port_status,
    output logic                   cfg_done
);

    logic                 cfg_load;
    logic [NUM_PORTS-1:0] deb_v;
    logic [NUM_PORTS-1:0] raw_v;
    logic                 deb_any;
    logic                 raw_any;

    cpm_cfg_ctl #(.INIT_MS(INIT_MS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1ms),
        .cfg_load (cfg_load),
        .cfg_done (cfg_done)
    );

    assign deb_any = |deb_v;
    assign raw_any = |raw_v;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic sel_deb, sel_raw, is_dcp;
        logic [1:0] st;

        cpm_sync_deb #(.DEB_MS(DEB_MS)) u_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_1ms),
            .ocs_n   (ocs_n[p]),
            .flt_raw (raw_v[p]),
            .flt_deb (deb_v[p])
        );

        assign sel_deb = gang_mode ? deb_any : deb_v[p];
        assign sel_raw = gang_mode ? raw_any : raw_v[p];
        assign is_dcp  = chg_en[p+1] && !host_link;

        cpm_port_fsm #(
            .SHORT_OFF_MS (SHORT_OFF_MS),
            .LONG_OFF_MS  (LONG_OFF_MS),
            .PRESENT_MS   (PRESENT_MS),
            .CLEAN_MS     (CLEAN_MS),
            .SHORT_TRIES  (SHORT_TRIES)
        ) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_1ms),
            .cfg_load (cfg_load),
            .cfg_dcp  (is_dcp),
            .flt_deb  (sel_deb),
            .flt_raw  (sel_raw),
            .host_req (host_req[p]),
            .pwr_en   (port_pwr_en[p]),
            .status   (st)
        );

        assign port_status[2*p +: 2] = st;
    end

    // R2: no port is powered before configuration completes
    p_pwr_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (port_pwr_en == '0));

endmodule

// File: tb/chgport_retry_mgr_bench.sv
module chgport_retry_mgr_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b1;
    logic [1:0] ocs_n = 2'b11;
    logic [2:1] chg_en = 2'b00;
    logic       host_link = 1'b0;
    logic       gang_mode = 1'b0;
    logic [1:0] host_req = 2'b00;
    logic [1:0] pwr;
    logic [3:0] stat;
    logic       cfg_done;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    chgport_retry_mgr u_chgport_retry_mgr (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_1ms    (tick_1ms),
        .ocs_n       (ocs_n),
        .chg_en      (chg_en),
        .host_link   (host_link),
        .gang_mode   (gang_mode),
        .host_req    (host_req),
        .port_pwr_en (pwr),
        .port_status (stat),
        .cfg_done    (cfg_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:1] c, input logic hl, input logic g);
        @(negedge clk);
        rst_n     = 1'b0;
        chg_en    = c;
        host_link = hl;
        gang_mode = g;
        ocs_n     = 2'b11;
        waitn(3);
        rst_n = 1'b1;
    endtask

    task automatic pulse_fault(input int port, input int len);
        ocs_n[port] = 1'b0;
        waitn(len);
        ocs_n[port] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // ---- Config A: both ports dedicated charging, individual switching
        host_req = 2'b11;
        do_reset(2'b11, 1'b0, 1'b0);
        waitn(1);
        chk("R2 pwr low during init", {30'd0, pwr}, 32'h0);
        chk("R2 cfg_done low during init", {31'd0, cfg_done}, 32'h0);
        waitn(10);
        chk("R2 dcp ports powered after init", {30'd0, pwr}, 32'h3);
        chk("R11 status powered", {28'd0, stat}, 32'h0);

        // R3: a glitch shorter than the debounce time is ignored
        pulse_fault(0, 4);
        waitn(30);
        chk("R3 short glitch ignored", {30'd0, pwr}, 32'h3);

        // R3/R4/R5: fault on port index 1, individual mode
        ocs_n[1] = 1'b0;
        waitn(5);
        chk("R3 still powered before debounce", {31'd0, pwr[1]}, 32'h1);
        waitn(15);
        chk("R4 individual: only faulted port off", {30'd0, pwr}, 32'h1);
        chk("R11 status short retry", {30'd0, stat[3:2]}, 32'h1);
        ocs_n[1] = 1'b1;
        waitn(500);
        chk("R5 off during short period", {31'd0, pwr[1]}, 32'h0);
        waitn(600);
        chk("R5 re-enabled after short period", {31'd0, pwr[1]}, 32'h1);
        chk("R5 status powered after re-enable", {30'd0, stat[3:2]}, 32'h0);

        // R6/R7: persistent fault on port index 0
        ocs_n[0] = 1'b0;
        waitn(20);
        chk("R6 off after persistent fault", {31'd0, pwr[0]}, 32'h0);
        waitn(1500);
        chk("R6 second period still short", {30'd0, stat[1:0]}, 32'h1);
        waitn(1080);
        chk("R6 third period still short", {30'd0, stat[1:0]}, 32'h1);
        waitn(900);
        chk("R7 fourth period long", {30'd0, stat[1:0]}, 32'h2);
        waitn(4500);
        ocs_n[0] = 1'b1;
        waitn(4800);
        chk("R7 still off late in long period", {31'd0, pwr[0]}, 32'h0);
        chk("R7 long status held", {30'd0, stat[1:0]}, 32'h2);
        waitn(400);
        chk("R7 re-enabled after long period", {31'd0, pwr[0]}, 32'h1);
        chk("R7 status powered", {30'd0, stat[1:0]}, 32'h0);

        // R8: fault before clean interval continues the count -> long
        pulse_fault(0, 30);
        waitn(2000);
        chk("R8 early refault goes long", {30'd0, stat[1:0]}, 32'h2);
        waitn(8200);
        chk("R8 back on after long", {31'd0, pwr[0]}, 32'h1);
        waitn(1200);
        pulse_fault(0, 30);
        waitn(470);
        chk("R8 clean interval resets count -> short", {30'd0, stat[1:0]}, 32'h1);
        waitn(600);
        chk("R8 short period ended", {31'd0, pwr[0]}, 32'h1);

        // ---- Config B: both dedicated charging, ganged
        do_reset(2'b11, 1'b0, 1'b1);
        waitn(10);
        chk("R2 ganged ports powered", {30'd0, pwr}, 32'h3);
        pulse_fault(1, 30);
        chk("R4 gang: all ports off", {30'd0, pwr}, 32'h0);
        chk("R4 gang: both short status", {28'd0, stat}, 32'h5);
        waitn(1100);
        chk("R4 gang: all ports restored", {30'd0, pwr}, 32'h3);

        // ---- Config C: both standard (charging bits clear)
        host_req = 2'b11;
        do_reset(2'b00, 1'b0, 1'b0);
        waitn(1);
        chk("R2 host ports off during init", {30'd0, pwr}, 32'h0);
        waitn(10);
        chk("R11 standard ports host status", {28'd0, stat}, 32'hF);
        for (int r = 0; r < 4; r++) begin
            host_req = r[1:0];
            waitn(1);
            chk("R9 pwr follows host request", {30'd0, pwr}, r);
        end
        host_req = 2'b11;
        ocs_n[0] = 1'b0;
        waitn(20);
        chk("R9 fault drops host port only", {30'd0, pwr}, 32'h2);
        ocs_n[0] = 1'b1;
        waitn(10);
        chk("R9 host port restored, not latched", {30'd0, pwr}, 32'h3);

        // ---- Config D: port 1 dedicated, port 2 standard (bit positions)
        host_req = 2'b00;
        do_reset(2'b01, 1'b0, 1'b0);
        waitn(10);
        chk("R1 bit1 -> index0 dcp, bit2 -> index1 std", {28'd0, stat}, 32'hC);
        chk("R1 only dcp port powered", {30'd0, pwr}, 32'h1);
        chg_en    = 2'b10;
        host_link = 1'b1;
        waitn(20);
        chk("R10 mode unchanged after config edit", {28'd0, stat}, 32'hC);
        chk("R10 power unchanged after config edit", {30'd0, pwr}, 32'h1);
        gang_mode = 1'b1;
        host_req  = 2'b10;
        waitn(2);
        chk("R9 host port on by request", {30'd0, pwr}, 32'h3);
        ocs_n[1] = 1'b0;
        waitn(20);
        chk("R4 gang across modes drops all", {30'd0, pwr}, 32'h0);
        ocs_n[1] = 1'b1;
        waitn(1100);
        chk("R4 gang across modes recovers", {30'd0, pwr}, 32'h3);

        // ---- Config E: charging bits set with host link -> charging downstream
        host_req = 2'b01;
        do_reset(2'b11, 1'b1, 1'b0);
        waitn(10);
        chk("R1 charging downstream is host controlled", {28'd0, stat}, 32'hF);
        chk("R1 charging downstream follows request", {30'd0, pwr}, 32'h1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule